// File: doc/BRIEF.md
# SPI Port with Word Request Handshake

This block is a 24-bit SPI port that runs as either bus master or bus slave. Each word moves MSB first with idle-low clock, data launched on the falling edge and captured on the rising edge. Pacing is done per word over an active-low request line whose direction follows the mode. As a slave, the port drives the line low when it can take the next word and releases it on the first clock pulse of that word. As a master, the port reads the line from the external slave, and a new low level on it starts each word.

In slave mode, an active-low select gates the port. While the select is high, incoming clock pulses do nothing and the slave data output is not driven. In master mode the select pin must stay high. A low level there sets a sticky bus-error flag, which stops any new master word until the flag is cleared by a write-one pulse. The master clock comes from the system clock through a programmable half-period divider. Slave-side clock, select, data and the request input pass through two-flop synchronizers.

The controller is one state machine with these states: IDLE, M_GAP (master waits for the request line to go high), M_WAIT (master waits for a low request with no error), M_SHIFT (master clocks a word), S_READY (slave requests a word) and S_SHIFT (slave shifts a word). Its transitions are:
- IDLE goes to M_GAP or S_READY, depending on the mode.
- M_GAP goes to M_WAIT once the request is seen high.
- M_WAIT goes to M_SHIFT on a low request while the error flag is clear.
- M_SHIFT goes to M_GAP on the 24th falling edge.
- S_READY goes to S_SHIFT on a selected rising edge.
- S_SHIFT goes back to S_READY on the 24th falling edge, or when the select is released (abort).
- Any state goes to IDLE when the mode changes under it.

Top module: `spi_req_port`

## Requirements
- R1: While rst_n is low, hreq_oe, miso_oe, bus_err and rx_valid are all 0.
- R2: In slave mode with req_en not 2'b00, hreq_oe is 1 and hreq_out is 0 (asserted) while the port waits for a word.
- R3: In slave mode, hreq_out goes to 1 (deasserted) one cycle after the port detects the first selected rising SCK edge of a word.
- R4: In slave mode with ss_n high, SCK edges change no state (no word is received, no tx_taken pulse, and the request stays asserted), and miso_oe is 0.
- R5: In slave mode, the word on mosi_in (MSB first, sampled on SCK rise) appears on rx_word. miso_out presents the bits of tx_word, MSB first, and each bit is valid before the rising edge that samples it.
- R6: In master mode, a word starts only after hreq_in is low. sck_out then makes 24 high pulses, each half period lasting clk_div+1 clock cycles. mosi_out carries tx_word MSB first, and the bits sampled from miso_in form rx_word.
- R7: After a master word, no further word starts until hreq_in has been seen high and then low again.
- R8: hreq_oe is 0 in master mode and whenever req_en is 2'b00.
- R9: In master mode, a low ss_n sets bus_err. If err_clr is high in the same cycle, the set takes priority.
- R10: bus_err stays set until err_clr is high while no set condition is present. While bus_err is set, no new master word starts.
- R11: rx_valid is a one-cycle pulse per completed word. In master mode it rises in the same cycle as the 24th falling edge of sck_out.
- R12: tx_taken pulses once per word, in the cycle that tx_word is latched for that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_master | input | 1 | 1 = master, 0 = slave |
| req_en | input | 2 | Request line enable; 2'b00 floats the request output |
| clk_div | input | 8 | Master SCK half period minus one, in clock cycles |
| err_clr | input | 1 | Write-one-to-clear for bus_err |
| tx_word | input | 24 | Word to transmit |
| tx_taken | output | 1 | Pulse: tx_word latched |
| rx_word | output | 24 | Last received word |
| rx_valid | output | 1 | Pulse: rx_word updated |
| bus_err | output | 1 | Sticky bus-error flag |
| ss_n | input | 1 | Active-low slave select |
| sck_in | input | 1 | SCK from external master |
| sck_out | output | 1 | SCK driven in master mode |
| sck_oe | output | 1 | SCK output enable |
| mosi_in | input | 1 | Serial data in (slave mode) |
| mosi_out | output | 1 | Serial data out (master mode) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_in | input | 1 | Serial data in (master mode) |
| miso_out | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | MISO output enable |
| hreq_in | input | 1 | Request line as seen on the pin (master mode input) |
| hreq_out | output | 1 | Request line drive value, active low |
| hreq_oe | output | 1 | Request line output enable |

## Verification
Setting the bus error and clearing it with the write-one pulse can fall in the same cycle. The bench provokes this by holding ss_n low in master mode and pulsing err_clr. The flag must stay high, and no master word may start even though the request line is asserted. The flag must then clear only after ss_n is released. The bench also runs a master word and a slave word back to back with mode switches between them. It judges the transmitted and received words at the pins, the request line level and the SCK half period.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_GAP,
        ST_M_WAIT,
        ST_M_SHIFT,
        ST_S_READY,
        ST_S_SHIFT
    } port_state_t;
endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
    parameter int             W    = 4,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_req_tick.sv
module spi_req_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt == div)  cnt <= '0;
        else                  cnt <= cnt + DIV_W'(1);
    end

    assign tick = run && (cnt == div);
endmodule

// File: rtl/spi_req_port.sv
module spi_req_port
    import spi_req_pkg::*;
#(
    parameter int WORD  = 24,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_master,
    input  logic [1:0]       req_en,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             err_clr,
    input  logic [WORD-1:0]  tx_word,
    output logic             tx_taken,
    output logic [WORD-1:0]  rx_word,
    output logic             rx_valid,
    output logic             bus_err,
    input  logic             ss_n,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic             mosi_in,
    output logic             mosi_out,
    output logic             mosi_oe,
    input  logic             miso_in,
    output logic             miso_out,
    output logic             miso_oe,
    input  logic             hreq_in,
    output logic             hreq_out,
    output logic             hreq_oe
);
    localparam int CNT_W = $clog2(WORD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD);

    port_state_t state, nxt;

    logic [3:0]      pin_s;
    logic            hreq_s, ss_act, sck_s, mosi_s, sck_d;
    logic            sck_rise, sck_fall, tick, sck_q, samp;
    logic [WORD-1:0] shreg;
    logic [CNT_W-1:0] bitcnt;
    logic            m_rise, m_fall;

    // Order: hreq_n, ss_n, sck, mosi; idle values are high, high, low, low
    spi_req_sync #(.W(4), .INIT(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hreq_in, ss_n, sck_in, mosi_in}),
        .q     (pin_s)
    );
    assign hreq_s = pin_s[3];
    assign ss_act = !pin_s[2];
    assign sck_s  = pin_s[1];
    assign mosi_s = pin_s[0];

    spi_req_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_M_SHIFT),
        .div   (clk_div),
        .tick  (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end
    assign sck_rise = sck_s && !sck_d;
    assign sck_fall = !sck_s && sck_d;
    assign m_rise   = (state == ST_M_SHIFT) && tick && !sck_q;
    assign m_fall   = (state == ST_M_SHIFT) && tick && sck_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = mode_master ? ST_M_GAP : ST_S_READY;
            ST_M_GAP:   if (!mode_master) nxt = ST_IDLE;
                        else if (hreq_s) nxt = ST_M_WAIT;
            ST_M_WAIT:  if (!mode_master) nxt = ST_IDLE;
                        else if (!hreq_s && !bus_err) nxt = ST_M_SHIFT;
            ST_M_SHIFT: if (!mode_master) nxt = ST_IDLE;
                        else if (m_fall && bitcnt == LAST) nxt = ST_M_GAP;
            ST_S_READY: if (mode_master) nxt = ST_IDLE;
                        else if (ss_act && sck_rise) nxt = ST_S_SHIFT;
            ST_S_SHIFT: if (mode_master) nxt = ST_IDLE;
                        else if (!ss_act) nxt = ST_S_READY;
                        else if (sck_fall && bitcnt == LAST) nxt = ST_S_READY;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            samp     <= 1'b0;
            bitcnt   <= '0;
            sck_q    <= 1'b0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
            tx_taken <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_taken <= 1'b0;
            unique case (state)
                ST_M_WAIT: begin
                    sck_q <= 1'b0;
                    if (nxt == ST_M_SHIFT) begin
                        shreg    <= tx_word;
                        bitcnt   <= '0;
                        tx_taken <= 1'b1;
                    end
                end
                ST_M_SHIFT: begin
                    if (m_rise) begin
                        sck_q  <= 1'b1;
                        samp   <= miso_in;
                        bitcnt <= bitcnt + CNT_W'(1);
                    end else if (m_fall) begin
                        sck_q <= 1'b0;
                        shreg <= {shreg[WORD-2:0], samp};
                        if (bitcnt == LAST) begin
                            rx_word  <= {shreg[WORD-2:0], samp};
                            rx_valid <= 1'b1;
                        end
                    end
                    if (!mode_master) sck_q <= 1'b0;
                end
                ST_S_READY: begin
                    sck_q <= 1'b0;
                    if (ss_act && sck_rise) begin
                        samp     <= mosi_s;
                        bitcnt   <= CNT_W'(1);
                        tx_taken <= 1'b1;
                    end else begin
                        shreg <= tx_word;
                    end
                end
                ST_S_SHIFT: begin
                    if (ss_act && sck_rise) begin
                        samp   <= mosi_s;
                        bitcnt <= bitcnt + CNT_W'(1);
                    end else if (ss_act && sck_fall) begin
                        shreg <= {shreg[WORD-2:0], samp};
                        if (bitcnt == LAST) begin
                            rx_word  <= {shreg[WORD-2:0], samp};
                            rx_valid <= 1'b1;
                        end
                    end
                end
                default: sck_q <= 1'b0;
            endcase
        end
    end

    // Sticky bus error: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     bus_err <= 1'b0;
        else if (mode_master && ss_act) bus_err <= 1'b1;
        else if (err_clr)               bus_err <= 1'b0;
    end

    // Outputs
    always_comb begin
        sck_out  = sck_q;
        sck_oe   = mode_master;
        mosi_out = shreg[WORD-1];
        mosi_oe  = mode_master;
        miso_out = shreg[WORD-1];
        miso_oe  = rst_n && !mode_master && ss_act;
        hreq_out = (state != ST_S_READY);
        hreq_oe  = rst_n && !mode_master && (req_en != 2'b00);
    end

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S_READY && !mode_master && ss_act && sck_rise) |=> hreq_out); // R3
    AST_FRESH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_M_GAP) |=> (state != ST_M_SHIFT)); // R7
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && ss_act) |=> bus_err); // R9
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !err_clr) |=> bus_err); // R10
    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_M_WAIT && bus_err) |=> (state != ST_M_SHIFT)); // R10
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R11
endmodule

// File: tb/spi_req_port_test.sv
module spi_req_port_test;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_master = 1'b0;
    logic [1:0]  req_en = 2'b01;
    logic [7:0]  clk_div = 8'd2;
    logic        err_clr = 1'b0;
    logic [23:0] tx_word = '0;
    logic        tx_taken;
    logic [23:0] rx_word;
    logic        rx_valid, bus_err;
    logic        ss_n = 1'b1, sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0, hreq_in = 1'b1;
    logic        sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, hreq_out, hreq_oe;

    int total = 0, bad = 0;
    int rx_cnt = 0, tk_cnt = 0;
    logic [23:0] last_rx = '0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_req_port uut (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .req_en(req_en),
        .clk_div(clk_div), .err_clr(err_clr), .tx_word(tx_word), .tx_taken(tx_taken),
        .rx_word(rx_word), .rx_valid(rx_valid), .bus_err(bus_err), .ss_n(ss_n),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .mosi_in(mosi_in),
        .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_in(miso_in), .miso_out(miso_out),
        .miso_oe(miso_oe), .hreq_in(hreq_in), .hreq_out(hreq_out), .hreq_oe(hreq_oe)
    );

    always @(posedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            last_rx <= rx_word;
        end
        if (tx_taken) tk_cnt <= tk_cnt + 1;
    end

    // {mode_master, tx_word, peer word}
    localparam logic [48:0] VEC [0:5] = '{
        {1'b1, 24'hA5C396, 24'h3C5A69},
        {1'b1, 24'hFFFFFF, 24'h000000},
        {1'b1, 24'h800001, 24'h7FFFFE},
        {1'b0, 24'h123456, 24'hFEDCBA},
        {1'b0, 24'h000000, 24'hFFFFFF},
        {1'b0, 24'hC00003, 24'h5AA5A5}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic master_xfer(input logic [23:0] peer, input bit release_req,
                               output logic [23:0] got, output int halfp, output bit rx_ok);
        int falls = 0;
        int since = 0;
        int guard = 0;
        logic prev;
        got = '0; halfp = 0; rx_ok = 1'b0;
        miso_in = peer[23];
        hreq_in = 1'b0;
        prev = sck_out;
        while (falls < 24 && guard < 5000) begin
            @(negedge clk);
            guard++;
            since++;
            if (sck_out && !prev) begin
                got = {got[22:0], mosi_out};
                since = 0;
            end else if (!sck_out && prev) begin
                falls++;
                if (falls == 1) halfp = since;
                since = 0;
                if (falls == 24) rx_ok = rx_valid && (rx_word == peer);
                else miso_in = peer[23 - falls];
            end
            prev = sck_out;
        end
        if (release_req) hreq_in = 1'b1;
    endtask

    task automatic slave_xfer(input logic [23:0] peer, output logic [23:0] got);
        got = '0;
        ss_n = 1'b0;
        wait_n(H);
        for (int i = 23; i >= 0; i--) begin
            mosi_in = peer[i];
            wait_n(H);
            got = {got[22:0], miso_out};
            if (i == 23) chk(hreq_out == 1'b0 && hreq_oe == 1'b1, "R2 request asserted before word", {hreq_oe, hreq_out}, 2'b10);
            sck_in = 1'b1;
            wait_n(H);
            if (i == 23) chk(hreq_out == 1'b1, "R3 request released after first rise", hreq_out, 1);
            sck_in = 1'b0;
        end
        wait_n(H);
        ss_n = 1'b1;
        wait_n(H);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [48:0] v;
        logic [23:0] g;
        int hp, t0, r0;
        bit ok;

        // R1: reset state
        wait_n(3);
        chk(hreq_oe == 0 && miso_oe == 0, "R1 enables low in reset", {hreq_oe, miso_oe}, 0);
        chk(bus_err == 0 && rx_valid == 0, "R1 flags low in reset", {bus_err, rx_valid}, 0);
        rst_n = 1'b1;
        wait_n(4);
        chk(hreq_oe == 1 && hreq_out == 0, "R2 slave requests after reset", {hreq_oe, hreq_out}, 2'b10);

        // Table of transfers
        for (int k = 0; k < 6; k++) begin
            v = VEC[k];
            mode_master = v[48];
            tx_word = v[47:24];
            wait_n(6);
            t0 = tk_cnt;
            r0 = rx_cnt;
            if (v[48]) begin
                chk(hreq_oe == 0, "R8 request floats in master", hreq_oe, 0);
                master_xfer(v[23:0], 1'b1, g, hp, ok);
                chk(ok, "R11 rx_valid with final SCK fall", {31'b0, ok}, 1);
                chk(g == v[47:24], "R6 mosi word", g, v[47:24]);
                chk(hp == 3, "R6 half period clk_div+1", hp, 3);
                wait_n(4);
                chk(last_rx == v[23:0], "R6 rx word", last_rx, v[23:0]);
            end else begin
                slave_xfer(v[23:0], g);
                chk(g == v[47:24], "R5 miso word", g, v[47:24]);
                chk(last_rx == v[23:0], "R5 rx word", last_rx, v[23:0]);
            end
            chk(rx_cnt == r0 + 1, "R11 one rx pulse per word", rx_cnt, r0 + 1);
            chk(tk_cnt == t0 + 1, "R12 one tx_taken per word", tk_cnt, t0 + 1);
        end

        // R4: SCK ignored while deselected
        mode_master = 1'b0;
        tx_word = 24'h0F0F0F;
        wait_n(6);
        t0 = tk_cnt;
        r0 = rx_cnt;
        for (int p = 0; p < 5; p++) begin
            sck_in = 1'b1;
            wait_n(H);
            if (p == 0) chk(miso_oe == 0, "R4 miso floats when deselected", miso_oe, 0);
            sck_in = 1'b0;
            wait_n(H);
        end
        chk(tk_cnt == t0 && rx_cnt == r0, "R4 no word on deselected SCK", tk_cnt - t0 + rx_cnt - r0, 0);
        chk(hreq_out == 0, "R4 request still asserted", hreq_out, 0);
        slave_xfer(24'h13579B, g);
        chk(g == 24'h0F0F0F && last_rx == 24'h13579B, "R4 word after ignored pulses", last_rx, 24'h13579B);

        // R8: request enable cleared
        req_en = 2'b00;
        wait_n(2);
        chk(hreq_oe == 0, "R8 request floats with req_en 00", hreq_oe, 0);
        req_en = 2'b10;
        wait_n(2);
        chk(hreq_oe == 1, "R8 request driven with req_en 10", hreq_oe, 1);

        // R7: fresh request needed
        mode_master = 1'b1;
        tx_word = 24'h5A5A5A;
        wait_n(6);
        master_xfer(24'h2468AC, 1'b0, g, hp, ok);
        t0 = tk_cnt;
        wait_n(100);
        chk(tk_cnt == t0 && sck_out == 0, "R7 no word while request stays low", tk_cnt - t0, 0);
        hreq_in = 1'b1;
        wait_n(5);
        master_xfer(24'h0000FF, 1'b1, g, hp, ok);
        chk(ok && g == 24'h5A5A5A, "R7 word after fresh request", g, 24'h5A5A5A);

        // R9/R10: bus error, set beats clear
        wait_n(5);
        ss_n = 1'b0;
        wait_n(4);
        chk(bus_err == 1, "R9 select low in master sets error", bus_err, 1);
        err_clr = 1'b1;
        wait_n(1);
        err_clr = 1'b0;
        wait_n(1);
        chk(bus_err == 1, "R9 set wins over clear", bus_err, 1);
        t0 = tk_cnt;
        hreq_in = 1'b0;
        wait_n(60);
        chk(tk_cnt == t0 && sck_out == 0, "R10 no master word while error", tk_cnt - t0, 0);
        hreq_in = 1'b1;
        ss_n = 1'b1;
        wait_n(6);
        chk(bus_err == 1, "R10 error sticky after release", bus_err, 1);
        err_clr = 1'b1;
        wait_n(1);
        err_clr = 1'b0;
        wait_n(1);
        chk(bus_err == 0, "R10 error cleared", bus_err, 0);
        tx_word = 24'hC3C3C3;
        master_xfer(24'h111111, 1'b1, g, hp, ok);
        chk(ok && g == 24'hC3C3C3, "R10 master resumes after clear", g, 24'hC3C3C3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule